// File: doc/BRIEF.md
# Receive Packet Polling and Select Interface

This block sits on the PHY side of a packet bus between a PHY and a link-layer device, and handles the receive direction. The link layer polls the block by presenting a port address. The block answers on a packet-available flag. The flag is raised when the polled address equals the block's own port number and the receive FIFO holds enough data. Enough data means the fill level has reached a programmable threshold, or a packet end is already stored. The FIFO itself is outside the block; it appears only as a fill level, an end-present flag, a data word and a pop strobe.

A two-bit mode field chooses between two bus disciplines.
- In the single-master discipline, the poll answer comes one clock after the address is sampled. The link layer opens a transfer by selecting the port out-of-band, using a select strobe with an address.
- In the PHY-led discipline, the poll answer comes two clocks after the address is sampled. The block opens read transfers by itself: it first places its own port number on the data bus for one cycle, marked by a start-address qualifier, and then streams packet words.

The block offers no arbitration, so the PHY-led discipline suits a bus with a single PHY. A new mode value is taken only while no transfer is open.

Top module: `rx_poll_if`

## Requirements
- R1: The mode field value 2'b01 selects the PHY-led discipline, and every other value selects the single-master discipline. The field is copied into the block one clock after it changes, provided no transfer is open.
- R2: The poll answer is 1 when, at the same clock edge, the sampled poll address equals the configured port number AND either fill level >= threshold or the end-present flag is 1. In every other case it is 0.
- R3: In the single-master discipline, the poll answer for an address sampled at edge k is visible after edge k and is replaced after edge k+1.
- R4: In the PHY-led discipline, the poll answer for an address sampled at edge k is visible after edge k+1. After edge k it still shows the previous answer.
- R5: In the single-master discipline, a select strobe opens a transfer when the select address equals the port number. A select strobe carrying any other address leaves the block idle: no pop and no valid output.
- R6: While a transfer is open and read enable is high, the FIFO pop is high in that same cycle. After the next edge, the output valid is 1, the output data equals the popped word and the output end flag equals that word's end flag. The transfer closes after the word flagged as end is popped.
- R7: In the PHY-led discipline, a transfer opens when the block is idle, read enable is high and a packet is available. For exactly one cycle, before any data word, the output shows the start-address qualifier = 1 and valid = 0, with data equal to the port number zero-extended.
- R8: In the PHY-led discipline the select strobe has no effect. In the single-master discipline the start-address qualifier never rises.
- R9: A mode change made while a transfer is open has no effect on poll latency or transfer start until that transfer has closed.
- R10: While reset is low, the poll answer, FIFO pop, output valid, start-address qualifier and output end flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Mode field; 2'b01 selects the PHY-led discipline |
| poll_addr | input | ADDR_W | Port address being polled |
| fill_level | input | FILL_W | Receive FIFO fill level |
| fill_thresh | input | FILL_W | Fill level at which a packet counts as available |
| eop_present | input | 1 | FIFO holds at least one packet end |
| sel_req | input | 1 | Out-of-band select strobe (single-master discipline) |
| sel_addr | input | ADDR_W | Address carried with the select strobe |
| rd_en | input | 1 | Link layer ready to accept words |
| fifo_dat | input | DATA_W | Word at the head of the FIFO |
| fifo_eop | input | 1 | Head word is the last word of a packet |
| fifo_pop | output | 1 | Remove the head word from the FIFO |
| pkt_avail | output | 1 | Poll answer |
| out_dat | output | DATA_W | Bus data: packet word or in-band port number |
| out_val | output | 1 | out_dat holds a packet word |
| out_soa | output | 1 | out_dat holds the in-band port number |
| out_eop | output | 1 | Word on out_dat ends the packet |

## Verification
The assertions assume three things about the FIFO: the poll inputs are defined from reset onward, the FIFO always has a head word whenever it is popped, and the link layer drops read enable once a packet end has been delivered. The bench meets these assumptions in the following way. It drives every input from the first cycle and supplies words only on cycles with read enable high. It clears the end-present flag before a PHY-led transfer closes, so no second transfer starts unintentionally. The poll sweep places a non-matching address before and after every polled address. Because of this, the cycle in which an answer appears identifies the latency without ambiguity.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
   localparam logic [1:0] MODE_LEAD = 2'b01;
   localparam int unsigned LAT_MAX = 2;

   typedef enum logic {
      XS_IDLE = 1'b0,
      XS_OPEN = 1'b1
   } xfer_state_t;
endpackage

// File: rtl/rxp_poll.sv
module rxp_poll
   import rxp_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned MY_PORT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lead_mode,
   input  logic [ADDR_W-1:0] poll_addr,
   input  logic              ready,
   output logic              avail
);
   localparam logic [ADDR_W-1:0] PORT_V = ADDR_W'(MY_PORT);

   logic [LAT_MAX-1:0] hit_q;
   logic               hit_now;

   assign hit_now = (poll_addr == PORT_V) && ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= '0;
      end else begin
         hit_q <= {hit_q[LAT_MAX-2:0], hit_now};
      end
   end

   // stage 0 answers after one clock, last stage after LAT_MAX clocks
   assign avail = lead_mode ? hit_q[LAT_MAX-1] : hit_q[0];
endmodule

// File: rtl/rxp_xfer.sv
module rxp_xfer
   import rxp_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned MY_PORT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lead_mode,
   input  logic              ready,
   input  logic              sel_req,
   input  logic [ADDR_W-1:0] sel_addr,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] fifo_dat,
   input  logic              fifo_eop,
   output logic              busy,
   output logic              fifo_pop,
   output logic [DATA_W-1:0] out_dat,
   output logic              out_val,
   output logic              out_soa,
   output logic              out_eop
);
   localparam logic [ADDR_W-1:0] PORT_V   = ADDR_W'(MY_PORT);
   localparam logic [DATA_W-1:0] PORT_BUS = DATA_W'(MY_PORT);

   xfer_state_t st_q, st_d;
   logic        open_lead, open_sel;

   assign open_lead = (st_q == XS_IDLE) && lead_mode && rd_en && ready;
   assign open_sel  = (st_q == XS_IDLE) && !lead_mode && sel_req && (sel_addr == PORT_V);
   assign busy      = (st_q == XS_OPEN);
   assign fifo_pop  = busy && rd_en;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         XS_IDLE: if (open_lead || open_sel) st_d = XS_OPEN;
         XS_OPEN: if (fifo_pop && fifo_eop) st_d = XS_IDLE;
         default: st_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= XS_IDLE;
         out_val <= 1'b0;
         out_soa <= 1'b0;
         out_eop <= 1'b0;
         out_dat <= '0;
      end else begin
         st_q    <= st_d;
         out_val <= fifo_pop;
         out_eop <= fifo_pop && fifo_eop;
         out_soa <= open_lead;
         if (fifo_pop)       out_dat <= fifo_dat;
         else if (open_lead) out_dat <= PORT_BUS;
         else                out_dat <= '0;
      end
   end
endmodule

// File: rtl/rx_poll_if.sv
module rx_poll_if
   import rxp_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned FILL_W  = 6,
   parameter int unsigned MY_PORT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic [ADDR_W-1:0] poll_addr,
   input  logic [FILL_W-1:0] fill_level,
   input  logic [FILL_W-1:0] fill_thresh,
   input  logic              eop_present,
   input  logic              sel_req,
   input  logic [ADDR_W-1:0] sel_addr,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] fifo_dat,
   input  logic              fifo_eop,
   output logic              fifo_pop,
   output logic              pkt_avail,
   output logic [DATA_W-1:0] out_dat,
   output logic              out_val,
   output logic              out_soa,
   output logic              out_eop
);
   generate
      if (DATA_W < ADDR_W) begin : g_bad_width
         $error("rx_poll_if: DATA_W must hold an in-band port address");
      end
      if (MY_PORT >= (1 << ADDR_W)) begin : g_bad_port
         $error("rx_poll_if: MY_PORT does not fit in ADDR_W bits");
      end
      if (LAT_MAX < 2) begin : g_bad_lat
         $error("rx_poll_if: poll pipeline needs two stages");
      end
   endgenerate

   logic lead_q;
   logic busy;
   logic ready;

   assign ready = (fill_level >= fill_thresh) || eop_present;

   always_ff @(posedge clk) begin
      if (!rst_n)     lead_q <= 1'b0;
      else if (!busy) lead_q <= (cfg_mode == MODE_LEAD);
   end

   rxp_poll #(
      .ADDR_W (ADDR_W),
      .MY_PORT(MY_PORT)
   ) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .lead_mode(lead_q),
      .poll_addr(poll_addr),
      .ready    (ready),
      .avail    (pkt_avail)
   );

   rxp_xfer #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MY_PORT(MY_PORT)
   ) u_xfer (
      .clk      (clk),
      .rst_n    (rst_n),
      .lead_mode(lead_q),
      .ready    (ready),
      .sel_req  (sel_req),
      .sel_addr (sel_addr),
      .rd_en    (rd_en),
      .fifo_dat (fifo_dat),
      .fifo_eop (fifo_eop),
      .busy     (busy),
      .fifo_pop (fifo_pop),
      .out_dat  (out_dat),
      .out_val  (out_val),
      .out_soa  (out_soa),
      .out_eop  (out_eop)
   );
endmodule

// File: rtl/rxp_checker.sv
module rxp_checker #(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned MY_PORT = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] poll_addr,
   input logic              pkt_avail,
   input logic              lead_q,
   input logic              busy,
   input logic              rd_en,
   input logic              out_val,
   input logic              out_soa,
   input logic              out_eop
);
   localparam logic [ADDR_W-1:0] PORT_V = ADDR_W'(MY_PORT);

   p_avail_addr_l2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_avail && !lead_q) |-> ($past(poll_addr) == PORT_V));

   p_avail_addr_l3_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_avail && lead_q) |-> ($past(poll_addr, 2) == PORT_V));

   p_val_needs_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_val |-> $past(rd_en));

   p_eop_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_val && out_eop) |=> !out_val);

   p_soa_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_soa |-> !out_val);

   p_soa_lead_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_soa |-> $past(lead_q));

   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(lead_q));
endmodule

bind rx_poll_if rxp_checker #(
   .ADDR_W (ADDR_W),
   .MY_PORT(MY_PORT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .poll_addr(poll_addr),
   .pkt_avail(pkt_avail),
   .lead_q   (lead_q),
   .busy     (busy),
   .rd_en    (rd_en),
   .out_val  (out_val),
   .out_soa  (out_soa),
   .out_eop  (out_eop)
);

// File: tb/rx_poll_if_bench.sv
module rx_poll_if_bench;
   localparam int PERIOD = 10;
   localparam int AW = 5;
   localparam int DW = 16;
   localparam int FW = 6;
   localparam int PORT = 9;
   localparam logic [AW-1:0] OTHER = ~AW'(PORT);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_mode = 2'b00;
   logic [AW-1:0] poll_addr = OTHER;
   logic [FW-1:0] fill_level = '0;
   logic [FW-1:0] fill_thresh = 6'd8;
   logic          eop_present = 1'b0;
   logic          sel_req = 1'b0;
   logic [AW-1:0] sel_addr = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] fifo_dat = '0;
   logic          fifo_eop = 1'b0;
   logic          fifo_pop, pkt_avail, out_val, out_soa, out_eop;
   logic [DW-1:0] out_dat;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   rx_poll_if #(.ADDR_W(AW), .DATA_W(DW), .FILL_W(FW), .MY_PORT(PORT)) u_rx_poll_if (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .poll_addr(poll_addr),
      .fill_level(fill_level), .fill_thresh(fill_thresh), .eop_present(eop_present),
      .sel_req(sel_req), .sel_addr(sel_addr), .rd_en(rd_en), .fifo_dat(fifo_dat),
      .fifo_eop(fifo_eop), .fifo_pop(fifo_pop), .pkt_avail(pkt_avail),
      .out_dat(out_dat), .out_val(out_val), .out_soa(out_soa), .out_eop(out_eop));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      cfg_mode = m;
      @(negedge clk);
      @(negedge clk);
   endtask

   // one poll pulse; lead selects the expected latency (R3 / R4)
   task automatic poll(input logic [AW-1:0] a, input logic [FW-1:0] f,
                       input logic e, input bit lead, input string tag);
      logic exp;
      exp = (a == AW'(PORT)) && ((f >= fill_thresh) || e);
      poll_addr = a; fill_level = f; eop_present = e;
      @(negedge clk);
      poll_addr = OTHER; eop_present = 1'b0; fill_level = '0;
      chk(tag, pkt_avail, lead ? 1'b0 : exp);
      @(negedge clk);
      chk(tag, pkt_avail, lead ? exp : 1'b0);
      @(negedge clk);
   endtask

   task automatic words(input logic [DW-1:0] base, input int n, input bit last, input bit lead);
      for (int i = 0; i < n; i++) begin
         fifo_dat = base + DW'(i);
         fifo_eop = last && (i == n - 1);
         rd_en = 1'b1;
         #1 chk("R6 pop with rd_en", fifo_pop, 1'b1);
         @(negedge clk);
         chk("R6 out_val", out_val, 1'b1);
         chk("R6 out_dat", out_dat, base + DW'(i));
         chk("R6 out_eop", out_eop, last && (i == n - 1));
         if (!lead) chk("R8 no soa in single-master", out_soa, 1'b0);
      end
      fifo_eop = 1'b0;
      if (last) begin
         #1 chk("R6 closed after end", fifo_pop, 1'b0);
         @(negedge clk);
         chk("R6 no word after end", out_val, 1'b0);
      end
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 avail in reset", pkt_avail, 1'b0);
      chk("R10 pop in reset", fifo_pop, 1'b0);
      chk("R10 val in reset", out_val, 1'b0);
      chk("R10 soa in reset", out_soa, 1'b0);
      chk("R10 eop in reset", out_eop, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1..R4 sweep: all modes, all addresses, threshold edges
      for (int m = 0; m < 4; m++) begin
         set_mode(2'(m));
         for (int a = 0; a < 32; a++) begin
            poll(AW'(a), fill_thresh - 6'd1, 1'b0, m == 1, m == 1 ? "R4 R1 R2 lat2" : "R3 R1 R2 lat1");
            poll(AW'(a), fill_thresh, 1'b0, m == 1, m == 1 ? "R4 R2 at thr" : "R3 R2 at thr");
            poll(AW'(a), 6'd0, 1'b1, m == 1, m == 1 ? "R4 R2 eop" : "R3 R2 eop");
         end
      end
      fill_thresh = 6'd63;
      poll(AW'(PORT), 6'd62, 1'b0, 1'b0, "R2 below max thr");
      poll(AW'(PORT), 6'd63, 1'b0, 1'b0, "R2 at max thr");
      fill_thresh = 6'd8;

      // R5: wrong select address ignored
      set_mode(2'b00);
      sel_req = 1'b1; sel_addr = OTHER;
      @(negedge clk);
      sel_req = 1'b0; rd_en = 1'b1;
      #1 chk("R5 wrong select no pop", fifo_pop, 1'b0);
      @(negedge clk);
      chk("R5 wrong select no val", out_val, 1'b0);
      rd_en = 1'b0;

      // R5/R6: matching select opens transfer
      sel_req = 1'b1; sel_addr = AW'(PORT);
      @(negedge clk);
      sel_req = 1'b0;
      words(16'h1100, 3, 1'b1, 1'b0);

      // R8: select ignored in PHY-led discipline
      set_mode(2'b01);
      sel_req = 1'b1; sel_addr = AW'(PORT);
      @(negedge clk);
      sel_req = 1'b0; rd_en = 1'b1;
      #1 chk("R8 select ignored in lead", fifo_pop, 1'b0);
      @(negedge clk);
      chk("R8 no val after select", out_val, 1'b0);
      chk("R8 no soa without packet", out_soa, 1'b0);

      // R7: PHY-led start with in-band address
      eop_present = 1'b1;
      @(negedge clk);
      eop_present = 1'b0;
      chk("R7 soa", out_soa, 1'b1);
      chk("R7 no val with soa", out_val, 1'b0);
      chk("R7 in-band port", out_dat, DW'(PORT));
      words(16'h2200, 4, 1'b1, 1'b1);
      chk("R7 soa single cycle", out_soa, 1'b0);

      // R7 via threshold
      fill_level = 6'd8; rd_en = 1'b1;
      @(negedge clk);
      fill_level = 6'd0;
      chk("R7 soa on threshold", out_soa, 1'b1);
      words(16'h3300, 1, 1'b1, 1'b1);

      // R9: mode change held off during a transfer
      set_mode(2'b00);
      sel_req = 1'b1; sel_addr = AW'(PORT);
      @(negedge clk);
      sel_req = 1'b0;
      words(16'h4400, 1, 1'b0, 1'b0);
      cfg_mode = 2'b01;
      @(negedge clk);
      @(negedge clk);
      poll(AW'(PORT), 6'd0, 1'b1, 1'b0, "R9 latency held during transfer");
      words(16'h4500, 2, 1'b1, 1'b0);
      @(negedge clk);
      @(negedge clk);
      poll(AW'(PORT), 6'd0, 1'b1, 1'b1, "R9 R1 new mode after close");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule